// File: doc/BRIEF.md
# On-Time Sample-Point Timer with Trip Response

This block sits between the PWM modulator of a synchronous buck controller and its two gate drivers. It takes the raw high-side command and produces the two gate enables, with a fixed non-overlap gap at each hand-over. While the high-side enable is on, it counts the on-time in clock ticks (10 ns at the intended 100 MHz). When that on-time ends, it stores three quarters of the count. In the next on-time, the stored value bounds a sense window. The high-side current comparator is only believed inside that window.

A comparator trip inside the window produces a one-cycle fault pulse. The block then lets the on-time in progress run out untouched. It allows the following on-time only half as long as the tripped one, then forces both gate enables off and raises a halt level for the start-up sequencer. A re-arm strobe from the sequencer returns the block to normal service, with the window limit cleared.

Top module: `onsamp_timer`

## Requirements
- R1: While reset is asserted and just after it, hs_gate, ls_gate, sense_win, fault_pulse and halted are all 0.
- R2: ls_gate is 1 only while hs_cmd is 0 and hs_cmd was also sampled 0 at the preceding 8 rising edges (DT_HL = 8). It drops in the same cycle that hs_cmd rises, so hs_gate and ls_gate are never 1 together.
- R3: Outside the trip sequence, hs_gate is 1 exactly when hs_cmd is 1 and was also sampled 1 at the preceding 9 rising edges (DT_LH = 9). It drops in the cycle hs_cmd falls.
- R4: The on-time count advances by one for each clock cycle in which hs_gate is 1. It saturates at 1023 (10 bits), so an on-time longer than 1023 cycles gives a limit of 766.
- R5: After an on-time of N counted cycles ends, the next on-time opens sense_win for its first (N>>1)+(N>>2) cycles of hs_gate, and for no others. sense_win is always 0 while hs_gate is 0.
- R6: After reset, and after a re-arm, the window limit is 0, so the first on-time opens no window and a trip during it has no effect.
- R7: While armed, sense_trip = 1 in a cycle with sense_win = 1 makes fault_pulse 1 for exactly the next cycle. A trip outside the window gives no fault.
- R8: After a fault, further trips give no more fault pulses until a re-arm.
- R9: After a fault, the on-time in progress is not cut. hs_gate follows R3 until hs_cmd falls.
- R10: The next on-time after that lasts at most M>>1 cycles of hs_gate, where M is the counted length of the tripped on-time. If hs_cmd ends it sooner, it ends there.
- R11: Once that shortened on-time is cut or ends, halted is 1 and both gate enables stay 0 until a re-arm. rearm = 1 while halted returns the block to armed in the next cycle.
- R12: rearm has no effect while halted is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one count per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_cmd | input | 1 | Raw high-side command from the modulator |
| sense_trip | input | 1 | High-side current comparator output |
| rearm | input | 1 | Sequencer strobe that leaves the halted state |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |
| sense_win | output | 1 | Current-sense window enable |
| fault_pulse | output | 1 | One-cycle over-current fault indication |
| halted | output | 1 | Both gates held off after a trip, awaiting re-arm |

## Verification
The bench goes after the window boundary, where a limit that is off by one would open sense_win a cycle early or late. It also checks the saturated count: a counter that wrapped would give a tiny window after a very long on-time. A directed trip on a one-cycle on-time makes the half-length on-time zero, which a design that tested the cut only at the end of an on-time would never leave. Random trips before any measurement and repeated trips after a fault show up as stray fault pulses. Re-arm strobes outside the halted state, if obeyed, would clear the limit or move the state and change later windows.

// File: rtl/onsamp_pkg.sv
package onsamp_pkg;
  typedef enum logic [1:0] {
    ST_ARMED  = 2'd0,
    ST_FINISH = 2'd1,
    ST_HALF   = 2'd2,
    ST_OFF    = 2'd3
  } trip_state_e;
endpackage

// File: rtl/onsamp_deadtime.sv
module onsamp_deadtime #(
  parameter int DT_HL = 8,
  parameter int DT_LH = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_cmd,
  input  logic allow_hs,
  input  logic allow_ls,
  output logic hs_req,
  output logic hs_gate,
  output logic ls_gate
);
  localparam int DT_MAX = (DT_HL > DT_LH) ? DT_HL : DT_LH;
  localparam int W = $clog2(DT_MAX + 1);
  localparam logic [W-1:0] HL_END = W'(DT_HL);
  localparam logic [W-1:0] LH_END = W'(DT_LH);

  logic [W-1:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else begin
      if (hs_cmd) begin
        lo_cnt <= '0;
        if (hi_cnt != LH_END) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
        if (lo_cnt != HL_END) lo_cnt <= lo_cnt + 1'b1;
      end
    end
  end

  assign hs_req  = hs_cmd && (hi_cnt == LH_END);
  assign hs_gate = hs_req && allow_hs;
  assign ls_gate = !hs_cmd && (lo_cnt == HL_END) && allow_ls;
endmodule

// File: rtl/onsamp_meter.sv
module onsamp_meter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_gate,
  input  logic             clr_lim,
  output logic [CNT_W-1:0] ton_cnt,
  output logic             end_evt,
  output logic             sense_win
);
  localparam logic [CNT_W-1:0] FULL = '1;

  logic [CNT_W-1:0] lim;

  assign end_evt   = !hs_gate && (ton_cnt != '0);
  assign sense_win = hs_gate && (ton_cnt < lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ton_cnt <= '0;
      lim     <= '0;
    end else begin
      if (hs_gate) begin
        if (ton_cnt != FULL) ton_cnt <= ton_cnt + 1'b1;
      end else if (end_evt) begin
        ton_cnt <= '0;
        lim     <= (ton_cnt >> 1) + (ton_cnt >> 2);
      end
      if (clr_lim) lim <= '0;
    end
  end
endmodule

// File: rtl/onsamp_trip_ctl.sv
module onsamp_trip_ctl
  import onsamp_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_req,
  input  logic [CNT_W-1:0] ton_cnt,
  input  logic             end_evt,
  input  logic             sense_win,
  input  logic             sense_trip,
  input  logic             rearm,
  output logic             allow_hs,
  output logic             allow_ls,
  output logic             clr_lim,
  output logic             fault_pulse,
  output logic             halted
);
  trip_state_e      st;
  logic [CNT_W-1:0] half_lim;
  logic             cut, detect;

  assign cut      = (st == ST_HALF) && (ton_cnt >= half_lim);
  assign detect   = (st == ST_ARMED) && sense_win && sense_trip;
  assign allow_hs = (st != ST_OFF) && !cut;
  assign allow_ls = (st != ST_OFF);
  assign halted   = (st == ST_OFF);
  assign clr_lim  = (st == ST_OFF) && rearm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_ARMED;
      half_lim    <= '0;
      fault_pulse <= 1'b0;
    end else begin
      fault_pulse <= detect;
      unique case (st)
        ST_ARMED:  if (detect) st <= ST_FINISH;
        ST_FINISH: if (end_evt) begin
                     st       <= ST_HALF;
                     half_lim <= ton_cnt >> 1;
                   end
        ST_HALF:   if ((hs_req && cut) || end_evt) st <= ST_OFF;
        ST_OFF:    if (rearm) st <= ST_ARMED;
        default:   st <= ST_ARMED;
      endcase
    end
  end
endmodule

// File: rtl/onsamp_timer.sv
module onsamp_timer #(
  parameter int CNT_W = 10,
  parameter int DT_HL = 8,
  parameter int DT_LH = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_cmd,
  input  logic sense_trip,
  input  logic rearm,
  output logic hs_gate,
  output logic ls_gate,
  output logic sense_win,
  output logic fault_pulse,
  output logic halted
);
  logic             hs_req, allow_hs, allow_ls, clr_lim, end_evt;
  logic [CNT_W-1:0] ton_cnt;

  onsamp_deadtime #(.DT_HL(DT_HL), .DT_LH(DT_LH)) u_dt (
    .clk(clk), .rst_n(rst_n), .hs_cmd(hs_cmd),
    .allow_hs(allow_hs), .allow_ls(allow_ls),
    .hs_req(hs_req), .hs_gate(hs_gate), .ls_gate(ls_gate)
  );

  onsamp_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .hs_gate(hs_gate), .clr_lim(clr_lim),
    .ton_cnt(ton_cnt), .end_evt(end_evt), .sense_win(sense_win)
  );

  onsamp_trip_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .ton_cnt(ton_cnt),
    .end_evt(end_evt), .sense_win(sense_win), .sense_trip(sense_trip),
    .rearm(rearm), .allow_hs(allow_hs), .allow_ls(allow_ls),
    .clr_lim(clr_lim), .fault_pulse(fault_pulse), .halted(halted)
  );
endmodule

// File: rtl/onsamp_checks.sv
module onsamp_checks (
  input logic clk,
  input logic rst_n,
  input logic hs_cmd,
  input logic sense_trip,
  input logic rearm,
  input logic hs_gate,
  input logic ls_gate,
  input logic sense_win,
  input logic fault_pulse,
  input logic halted
);
  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));

  assert_ls_after_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> $past(!hs_cmd));

  assert_hs_needs_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hs_gate |-> hs_cmd);

  assert_win_inside_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sense_win |-> hs_gate);

  assert_fault_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_pulse) |-> $past(sense_win && sense_trip));

  assert_fault_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |=> !fault_pulse);

  assert_halt_gates_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!hs_gate && !ls_gate));

  assert_halt_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && rearm) |=> !halted);

  assert_halt_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !rearm) |=> halted);
endmodule

bind onsamp_timer onsamp_checks u_onsamp_checks (
  .clk(clk), .rst_n(rst_n), .hs_cmd(hs_cmd), .sense_trip(sense_trip),
  .rearm(rearm), .hs_gate(hs_gate), .ls_gate(ls_gate),
  .sense_win(sense_win), .fault_pulse(fault_pulse), .halted(halted)
);

// File: tb/tb_onsamp_timer.sv
module tb_onsamp_timer;
  localparam int HL = 8;
  localparam int LH = 9;
  localparam int SAT = 1023;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs_cmd = 1'b0, sense_trip = 1'b0, rearm = 1'b0;
  logic hs_gate, ls_gate, sense_win, fault_pulse, halted;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model state: 0 armed, 1 finish, 2 half, 3 off
  int m_lo = 0, m_hi = 0, m_ton = 0, m_lim = 0, m_half = 0, m_st = 0;
  bit m_fq = 1'b0;

  always #4 clk = ~clk;

  onsamp_timer dut (
    .clk(clk), .rst_n(rst_n), .hs_cmd(hs_cmd), .sense_trip(sense_trip),
    .rearm(rearm), .hs_gate(hs_gate), .ls_gate(ls_gate),
    .sense_win(sense_win), .fault_pulse(fault_pulse), .halted(halted)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit f_req(bit hc);
    return hc && (m_hi == LH);
  endfunction
  function automatic bit f_cut();
    return (m_st == 2) && (m_ton >= m_half);
  endfunction
  function automatic bit f_hs(bit hc);
    return f_req(hc) && (m_st != 3) && !f_cut();
  endfunction
  function automatic bit f_ls(bit hc);
    return !hc && (m_lo == HL) && (m_st != 3);
  endfunction
  function automatic bit f_win(bit hc);
    return f_hs(hc) && (m_ton < m_lim);
  endfunction

  task automatic model_step(input bit hc, input bit tr, input bit ra);
    bit ehs, det, endv;
    int n_st, n_lim, n_ton;
    ehs  = f_hs(hc);
    det  = (m_st == 0) && f_win(hc) && tr;
    endv = !ehs && (m_ton != 0);
    n_st = m_st; n_lim = m_lim; n_ton = m_ton;
    if (ehs) n_ton = (m_ton < SAT) ? m_ton + 1 : SAT;
    else if (endv) begin n_ton = 0; n_lim = (m_ton >> 1) + (m_ton >> 2); end
    case (m_st)
      0: if (det) n_st = 1;
      1: if (endv) begin n_st = 2; m_half = m_ton >> 1; end
      2: if ((f_req(hc) && f_cut()) || endv) n_st = 3;
      default: if (ra) begin n_st = 0; end
    endcase
    if (m_st == 3 && ra) n_lim = 0;
    m_lo = hc ? 0 : ((m_lo < HL) ? m_lo + 1 : HL);
    m_hi = hc ? ((m_hi < LH) ? m_hi + 1 : LH) : 0;
    m_fq = det; m_st = n_st; m_lim = n_lim; m_ton = n_ton;
  endtask

  task automatic cyc(input bit hc, input bit tr, input bit ra);
    string rh, rw, rf, rd;
    @(negedge clk);
    hs_cmd = hc; sense_trip = tr; rearm = ra;
    #1;
    rh = (m_st == 1) ? "R9" : ((m_st == 2) ? "R10" : "R3");
    rw = (m_lim == 0) ? "R6" : ((m_lim == 766) ? "R4" : "R5");
    rf = (m_st == 0) ? "R7" : "R8";
    rd = (ra && m_st != 3) ? "R12" : "R11";
    chk(rh, "hs_gate", hs_gate, f_hs(hc));
    chk("R2", "ls_gate", ls_gate, f_ls(hc));
    chk(rw, "sense_win", sense_win, f_win(hc));
    chk(rf, "fault_pulse", fault_pulse, m_fq);
    chk(rd, "halted", halted, m_st == 3);
    @(posedge clk);
    model_step(hc, tr, ra);
  endtask

  function automatic bit rnd_rearm();
    return ((m_st == 3) && ($urandom % 6 == 0)) || ($urandom % 50 == 0);
  endfunction

  task automatic burst(input int on_len, input int off_len, input int pct);
    for (int i = 0; i < on_len; i++) cyc(1'b1, ($urandom % 100) < pct, rnd_rearm());
    for (int i = 0; i < off_len; i++) cyc(1'b0, ($urandom % 100) < pct, rnd_rearm());
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    // R1: outputs quiet during reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R1", "hs_gate", hs_gate, 1'b0);
      chk("R1", "ls_gate", ls_gate, 1'b0);
      chk("R1", "sense_win", sense_win, 1'b0);
      chk("R1", "fault_pulse", fault_pulse, 1'b0);
      chk("R1", "halted", halted, 1'b0);
    end
    @(negedge clk); rst_n = 1'b1;

    // R6: first on-time, trip held high, no window and no fault
    for (int i = 0; i < 30; i++) cyc(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 15; i++) cyc(1'b0, 1'b1, 1'b0);
    // R12: rearm while armed must not clear the limit
    cyc(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 30; i++) cyc(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 15; i++) cyc(1'b0, 1'b0, 1'b0);

    // R4: saturating count, then a long on-time with limit 766
    for (int i = 0; i < 1100; i++) cyc(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 12; i++) cyc(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 900; i++) cyc(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 12; i++) cyc(1'b0, 1'b0, 1'b0);

    // R10: two-cycle on-time gives limit 1, trip on a one-cycle on-time -> zero half
    for (int i = 0; i < 11; i++) cyc(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 12; i++) cyc(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 11; i++) cyc(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 12; i++) cyc(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 12; i++) cyc(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 12; i++) cyc(1'b0, 1'b0, 1'b0);
    // R11: held off, then rearm
    cyc(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 12; i++) cyc(1'b0, 1'b0, 1'b0);

    // random on/off patterns with trips and rearm strobes
    for (int b = 0; b < 300; b++)
      burst(1 + $urandom % 60, 1 + $urandom % 25, $urandom % 12);

    done = 1'b1;
    summary();
  end
endmodule